// File: doc/BRIEF.md
# Core Run-State and Privilege Controller

This block holds the top-level run state of a small processor core and its supervisor/user privilege bit. The pipeline and the bus interface report events to it as single-cycle strobes: software traps, trace, bus access or address faults, an external interrupt with its priority level, the stop instruction, a debug halt request, the first instruction of a handler reaching the operand stage, return-from-exception, and a status-register write. From these it selects one of four states: running (`RS_NORMAL`), servicing an exception (`RS_EXCEPT`), stopped (`RS_STOPPED`) and halted (`RS_HALTED`).

On each entry to exception service the block raises a one-cycle request to stack the status register. It presents the privilege bit that held before entry, then forces supervisor mode. It also requests a refill of the fetch pipe. A stopped core issues no bus cycles, and only a nonmasked interrupt or reset wakes it. A fault that arrives while an exception is already being serviced, or a debug halt, sends the core to the halted state, which only reset leaves. The stacking datapath, vector fetch and instruction decode lie outside the block and are seen only through these strobes and requests.

The named transitions are:
- reset entry into `RS_EXCEPT`
- handler issue (`RS_EXCEPT` to `RS_NORMAL`)
- exception entry (`RS_NORMAL` or `RS_STOPPED` to `RS_EXCEPT`)
- stop entry (`RS_NORMAL` to `RS_STOPPED`)
- double fault (`RS_EXCEPT` to `RS_HALTED`)
- debug halt (`RS_NORMAL` or `RS_EXCEPT` to `RS_HALTED`)
- status load (`RS_NORMAL` to `RS_NORMAL`, new privilege bit)

Top module: `core_run_state`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, the block shows state_o = 1 (`RS_EXCEPT`), sup_o = 1, bus_en_o = 1, push_sr_o = 0 and refill_o = 1. One cycle after release with no events, refill_o is 0. The state codes are 0 = normal, 1 = exception, 2 = stopped and 3 = halted.
- R2: In `RS_EXCEPT`, hdl_issue_i moves the state to `RS_NORMAL` one cycle later. An interrupt or trap seen in `RS_EXCEPT` has no effect.
- R3: In `RS_NORMAL`, any of the following moves the state to `RS_EXCEPT` on the next cycle: trap, trace, access error, address error or a nonmasked interrupt. In that cycle push_sr_o and refill_o are 1 for exactly one cycle, saved_sup_o equals the privilege bit from before the event, and sup_o is 1.
- R4: The stop, RTE and status-write strobes are privileged. With sup_o = 0, each of them causes an exception entry as in R3 and has no other effect.
- R5: A stop strobe with sup_o = 1 in `RS_NORMAL` enters `RS_STOPPED` on the next cycle, and bus_en_o is then 0.
- R6: In `RS_STOPPED` the following are ignored and the state stays the same: faults, traps, trace, debug halt and masked interrupts. A nonmasked interrupt causes an exception entry as in R3.
- R7: An interrupt is nonmasked when its level is all ones (7 with a 3-bit level) or is strictly greater than the mask. A level equal to the mask is masked.
- R8: An access or address error while in `RS_EXCEPT` enters `RS_HALTED`. In `RS_HALTED` every event is ignored, bus_en_o is 0, and only reset leaves.
- R9: dbg_halt_i in `RS_NORMAL` or `RS_EXCEPT` enters `RS_HALTED` on the next cycle, and push_sr_o stays 0.
- R10: RTE or status write with sup_o = 1 loads sup_o from new_sup_i on the next cycle, and the state stays `RS_NORMAL`. RTE also pulses refill_o for one cycle. A status write does not.
- R11: When events coincide, the order of precedence from highest to lowest is: reset, double fault, debug halt, access or address error, interrupt, then trap, trace or privilege violation, then stop, then status load. A double fault also beats handler issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| trap_i | input | 1 | Trap instruction executed |
| trace_i | input | 1 | Trace exception raised |
| acc_err_i | input | 1 | Bus access error |
| addr_err_i | input | 1 | Address error |
| irq_i | input | 1 | Interrupt request present |
| irq_level_i | input | LEVEL_W | Interrupt priority level |
| irq_mask_i | input | LEVEL_W | Interrupt mask field of the status register |
| stop_i | input | 1 | Stop instruction issued |
| dbg_halt_i | input | 1 | Debug halt request |
| hdl_issue_i | input | 1 | First handler instruction reached the operand stage |
| rte_i | input | 1 | Return from exception issued |
| sr_wr_i | input | 1 | Write to status register issued |
| new_sup_i | input | 1 | Privilege bit carried by the RTE or status write |
| state_o | output | 2 | Current run state |
| sup_o | output | 1 | Privilege bit, 1 = supervisor |
| bus_en_o | output | 1 | Bus cycles allowed |
| push_sr_o | output | 1 | One-cycle request to stack the status register |
| saved_sup_o | output | 1 | Privilege bit to be stacked |
| refill_o | output | 1 | One-cycle request to refill the fetch pipe |

## Verification
The bench builds the block with the default 3-bit interrupt level. The all-ones level is then 7, so a small set of stimuli covers two boundaries: a level equal to the mask, which must be masked, and a level of 7 under a mask of 7, which must be taken. With this width, every level and mask pair that matters for waking from the stopped state can be reached directly. The bench also walks each privileged strobe in both privilege modes and pairs conflicting strobes in single cycles, so that the order of precedence shows in the next state.

// File: rtl/run_state_pkg.sv
package run_state_pkg;

    typedef enum logic [1:0] {
        RS_NORMAL  = 2'd0,
        RS_EXCEPT  = 2'd1,
        RS_STOPPED = 2'd2,
        RS_HALTED  = 2'd3
    } run_state_e;

    typedef enum logic [3:0] {
        C_NONE     = 4'd0,
        C_DBLFAULT = 4'd1,
        C_DBG      = 4'd2,
        C_BUSERR   = 4'd3,
        C_IRQ      = 4'd4,
        C_SW       = 4'd5,
        C_STOP     = 4'd6,
        C_SRLOAD   = 4'd7,
        C_HDL      = 4'd8
    } cause_e;

endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int LEVEL_W = 3
) (
    input  logic               req_i,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [LEVEL_W-1:0] mask_i,
    output logic               take_o
);
    localparam logic [LEVEL_W-1:0] TOP_LEVEL = {LEVEL_W{1'b1}};

    always_comb begin
        take_o = req_i && ((level_i == TOP_LEVEL) || (level_i > mask_i));
    end
endmodule

// File: rtl/cause_sel.sv
module cause_sel
    import run_state_pkg::*;
(
    input  run_state_e state_i,
    input  logic       sup_i,
    input  logic       trap_i,
    input  logic       trace_i,
    input  logic       fault_i,
    input  logic       irq_take_i,
    input  logic       stop_i,
    input  logic       dbg_halt_i,
    input  logic       hdl_issue_i,
    input  logic       rte_i,
    input  logic       sr_wr_i,
    output cause_e     cause_o
);
    logic priv_op;
    logic sw_exc;

    always_comb begin
        priv_op = stop_i | rte_i | sr_wr_i;
        sw_exc  = trap_i | trace_i | (priv_op & ~sup_i);
        cause_o = C_NONE;
        unique case (state_i)
            RS_NORMAL: begin
                if (dbg_halt_i)      cause_o = C_DBG;
                else if (fault_i)    cause_o = C_BUSERR;
                else if (irq_take_i) cause_o = C_IRQ;
                else if (sw_exc)     cause_o = C_SW;
                else if (stop_i)     cause_o = C_STOP;
                else if (rte_i | sr_wr_i) cause_o = C_SRLOAD;
            end
            RS_EXCEPT: begin
                if (fault_i)          cause_o = C_DBLFAULT;
                else if (dbg_halt_i)  cause_o = C_DBG;
                else if (hdl_issue_i) cause_o = C_HDL;
            end
            RS_STOPPED: begin
                if (irq_take_i)       cause_o = C_IRQ;
            end
            RS_HALTED: begin
                cause_o = C_NONE;
            end
            default: cause_o = C_NONE;
        endcase
    end
endmodule

// File: rtl/core_run_state.sv
module core_run_state
    import run_state_pkg::*;
#(
    parameter int LEVEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trap_i,
    input  logic               trace_i,
    input  logic               acc_err_i,
    input  logic               addr_err_i,
    input  logic               irq_i,
    input  logic [LEVEL_W-1:0] irq_level_i,
    input  logic [LEVEL_W-1:0] irq_mask_i,
    input  logic               stop_i,
    input  logic               dbg_halt_i,
    input  logic               hdl_issue_i,
    input  logic               rte_i,
    input  logic               sr_wr_i,
    input  logic               new_sup_i,
    output logic [1:0]         state_o,
    output logic               sup_o,
    output logic               bus_en_o,
    output logic               push_sr_o,
    output logic               saved_sup_o,
    output logic               refill_o
);
    run_state_e state_q, state_d;
    logic       sup_q, sup_d;
    logic       push_q, push_d;
    logic       saved_q, saved_d;
    logic       refill_q, refill_d;
    logic       irq_take;
    cause_e     cause;

    irq_gate #(.LEVEL_W(LEVEL_W)) u_irq_gate (
        .req_i   (irq_i),
        .level_i (irq_level_i),
        .mask_i  (irq_mask_i),
        .take_o  (irq_take)
    );

    cause_sel u_cause_sel (
        .state_i     (state_q),
        .sup_i       (sup_q),
        .trap_i      (trap_i),
        .trace_i     (trace_i),
        .fault_i     (acc_err_i | addr_err_i),
        .irq_take_i  (irq_take),
        .stop_i      (stop_i),
        .dbg_halt_i  (dbg_halt_i),
        .hdl_issue_i (hdl_issue_i),
        .rte_i       (rte_i),
        .sr_wr_i     (sr_wr_i),
        .cause_o     (cause)
    );

    // Next-state and next-output selection from the arbitrated cause
    always_comb begin
        state_d  = state_q;
        sup_d    = sup_q;
        push_d   = 1'b0;
        saved_d  = saved_q;
        refill_d = 1'b0;
        unique case (cause)
            C_DBLFAULT, C_DBG: begin
                state_d = RS_HALTED;
            end
            C_BUSERR, C_IRQ, C_SW: begin
                state_d  = RS_EXCEPT;
                push_d   = 1'b1;
                saved_d  = sup_q;
                sup_d    = 1'b1;
                refill_d = 1'b1;
            end
            C_STOP: begin
                state_d = RS_STOPPED;
            end
            C_SRLOAD: begin
                sup_d    = new_sup_i;
                refill_d = rte_i;
            end
            C_HDL: begin
                state_d = RS_NORMAL;
            end
            C_NONE: begin
                state_d = state_q;
            end
            default: begin
                state_d = state_q;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RS_EXCEPT;
            sup_q    <= 1'b1;
            push_q   <= 1'b0;
            saved_q  <= 1'b1;
            refill_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            sup_q    <= sup_d;
            push_q   <= push_d;
            saved_q  <= saved_d;
            refill_q <= refill_d;
        end
    end

    // Outputs
    always_comb begin
        state_o     = state_q;
        sup_o       = sup_q;
        push_sr_o   = push_q;
        saved_sup_o = saved_q;
        refill_o    = refill_q;
        bus_en_o    = (state_q == RS_NORMAL) || (state_q == RS_EXCEPT);
    end
endmodule

// File: rtl/core_run_state_chk.sv
module core_run_state_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       stop_i,
    input logic       hdl_issue_i,
    input logic [1:0] state_o,
    input logic       sup_o,
    input logic       bus_en_o,
    input logic       push_sr_o
);
    localparam logic [1:0] ST_NORMAL  = 2'd0;
    localparam logic [1:0] ST_EXCEPT  = 2'd1;
    localparam logic [1:0] ST_STOPPED = 2'd2;
    localparam logic [1:0] ST_HALTED  = 2'd3;

    a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HALTED) |=> (state_o == ST_HALTED));

    a_r8_halt_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_HALTED) |-> !bus_en_o);

    a_r5_stopped_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_STOPPED) |-> !bus_en_o);

    a_r3_push_in_except: assert property (@(posedge clk) disable iff (!rst_n)
        push_sr_o |-> (state_o == ST_EXCEPT) && sup_o);

    a_r3_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        push_sr_o |=> !push_sr_o);

    a_r2_exit_on_handler: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == ST_NORMAL) && ($past(state_o) == ST_EXCEPT)) |-> $past(hdl_issue_i));

    a_r6_stop_exit_to_except: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(state_o) == ST_STOPPED) && (state_o != ST_STOPPED)) |-> (state_o == ST_EXCEPT));

    a_r4_user_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == ST_NORMAL) && !sup_o && stop_i) |=> (state_o != ST_STOPPED));
endmodule

bind core_run_state core_run_state_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_i      (stop_i),
    .hdl_issue_i (hdl_issue_i),
    .state_o     (state_o),
    .sup_o       (sup_o),
    .bus_en_o    (bus_en_o),
    .push_sr_o   (push_sr_o)
);

// File: tb/core_run_state_bench.sv
module core_run_state_bench;
    localparam int LW = 3;
    localparam int E_TRAP  = 1;
    localparam int E_TRACE = 2;
    localparam int E_ACC   = 4;
    localparam int E_ADDR  = 8;
    localparam int E_IRQ   = 16;
    localparam int E_STOP  = 32;
    localparam int E_DBG   = 64;
    localparam int E_HDL   = 128;
    localparam int E_RTE   = 256;
    localparam int E_SRW   = 512;
    localparam int S_N = 0, S_E = 1, S_S = 2, S_H = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_i = 0, trace_i = 0, acc_err_i = 0, addr_err_i = 0, irq_i = 0;
    logic [LW-1:0] irq_level_i = '0, irq_mask_i = '0;
    logic stop_i = 0, dbg_halt_i = 0, hdl_issue_i = 0, rte_i = 0, sr_wr_i = 0, new_sup_i = 0;
    logic [1:0] state_o;
    logic sup_o, bus_en_o, push_sr_o, saved_sup_o, refill_o;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int    st;
        bit    sup;
        bit    push;
        bit    saved;
        bit    refill;
        string tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    core_run_state #(.LEVEL_W(LW)) u_core_run_state (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .trace_i(trace_i),
        .acc_err_i(acc_err_i), .addr_err_i(addr_err_i), .irq_i(irq_i),
        .irq_level_i(irq_level_i), .irq_mask_i(irq_mask_i), .stop_i(stop_i),
        .dbg_halt_i(dbg_halt_i), .hdl_issue_i(hdl_issue_i), .rte_i(rte_i),
        .sr_wr_i(sr_wr_i), .new_sup_i(new_sup_i), .state_o(state_o),
        .sup_o(sup_o), .bus_en_o(bus_en_o), .push_sr_o(push_sr_o),
        .saved_sup_o(saved_sup_o), .refill_o(refill_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        chk(state_o == e.st[1:0], e.tag, "state", state_o, e.st);
        chk(sup_o == e.sup, e.tag, "sup", sup_o, e.sup);
        chk(bus_en_o == (e.st == S_N || e.st == S_E), e.tag, "bus_en", bus_en_o,
            (e.st == S_N || e.st == S_E));
        chk(push_sr_o == e.push, e.tag, "push", push_sr_o, e.push);
        if (e.push) chk(saved_sup_o == e.saved, e.tag, "saved_sup", saved_sup_o, e.saved);
        chk(refill_o == e.refill, e.tag, "refill", refill_o, e.refill);
    endtask

    // Monitor: one expected item per clock edge, sampled 1 ns after it
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) compare(q.pop_front());
    end

    task automatic set_ev(input int ev, input int lvl, input int msk, input bit ns);
        trap_i      = (ev & E_TRAP) != 0;
        trace_i     = (ev & E_TRACE) != 0;
        acc_err_i   = (ev & E_ACC) != 0;
        addr_err_i  = (ev & E_ADDR) != 0;
        irq_i       = (ev & E_IRQ) != 0;
        stop_i      = (ev & E_STOP) != 0;
        dbg_halt_i  = (ev & E_DBG) != 0;
        hdl_issue_i = (ev & E_HDL) != 0;
        rte_i       = (ev & E_RTE) != 0;
        sr_wr_i     = (ev & E_SRW) != 0;
        irq_level_i = lvl[LW-1:0];
        irq_mask_i  = msk[LW-1:0];
        new_sup_i   = ns;
    endtask

    // Driver: apply one cycle of events and queue the expected result
    task automatic cyc(input int ev, input int lvl, input int msk, input bit ns,
                       input int st, input bit sup, input bit push, input bit saved,
                       input bit refill, input string tag);
        exp_t e;
        @(negedge clk);
        set_ev(ev, lvl, msk, ns);
        e.st = st; e.sup = sup; e.push = push; e.saved = saved; e.refill = refill; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        set_ev(0, 0, 0, 0);
        rst_n = 1'b0;
        #1;
        chk(state_o == 2'd1, "R1", "reset state", state_o, 1);
        chk(sup_o == 1'b1, "R1", "reset sup", sup_o, 1);
        chk(bus_en_o == 1'b1, "R1", "reset bus_en", bus_en_o, 1);
        chk(push_sr_o == 1'b0, "R1", "reset push", push_sr_o, 0);
        chk(refill_o == 1'b1, "R1", "reset refill", refill_o, 1);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        cyc(0,      0, 0, 0, S_E, 1, 0, 0, 0, "R1 idle after reset");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_STOP, 0, 0, 0, S_S, 1, 0, 0, 0, "R5 stop in supervisor");
        cyc(E_IRQ,  3, 3, 0, S_S, 1, 0, 0, 0, "R7 level equal mask masked");
        cyc(E_TRAP|E_ACC|E_ADDR|E_DBG|E_TRACE, 0, 0, 0, S_S, 1, 0, 0, 0, "R6 stopped ignores");
        cyc(E_IRQ,  4, 3, 0, S_E, 1, 1, 1, 1, "R6 nonmasked wakes");
        cyc(0,      0, 0, 0, S_E, 1, 0, 0, 0, "R3 push single cycle");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_SRW,  0, 0, 0, S_N, 0, 0, 0, 0, "R10 status write to user");
        cyc(E_STOP, 0, 0, 0, S_E, 1, 1, 0, 1, "R4 stop in user");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_RTE,  0, 0, 0, S_N, 0, 0, 0, 1, "R10 rte to user refills");
        cyc(E_RTE,  0, 0, 1, S_E, 1, 1, 0, 1, "R4 rte in user");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_SRW,  0, 0, 0, S_N, 0, 0, 0, 0, "R10 status write");
        cyc(E_SRW,  0, 0, 1, S_E, 1, 1, 0, 1, "R4 status write in user");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_SRW,  0, 0, 0, S_N, 0, 0, 0, 0, "R10 status write");
        cyc(E_TRAP, 0, 0, 0, S_E, 1, 1, 0, 1, "R3 trap from user");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_TRACE,0, 0, 0, S_E, 1, 1, 1, 1, "R3 trace from supervisor");
        cyc(E_IRQ|E_TRAP, 7, 7, 0, S_E, 1, 0, 0, 0, "R2 irq and trap ignored in exception");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_IRQ,  7, 7, 0, S_E, 1, 1, 1, 1, "R7 top level under top mask");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_IRQ,  2, 5, 0, S_N, 1, 0, 0, 0, "R7 level below mask masked");
        cyc(E_TRAP|E_STOP, 0, 0, 0, S_E, 1, 1, 1, 1, "R11 trap beats stop");
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_DBG|E_ACC|E_IRQ, 7, 0, 0, S_H, 1, 0, 0, 0, "R11 debug beats fault");
        cyc(E_IRQ|E_HDL|E_TRAP|E_STOP|E_RTE, 7, 0, 0, S_H, 1, 0, 0, 0, "R8 halted ignores");
        do_reset();
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_ACC,  0, 0, 0, S_E, 1, 1, 1, 1, "R3 access error entry");
        cyc(E_ADDR, 0, 0, 0, S_H, 1, 0, 0, 0, "R8 double fault halts");
        cyc(0,      0, 0, 0, S_H, 1, 0, 0, 0, "R8 halt holds");
        do_reset();
        cyc(E_DBG,  0, 0, 0, S_H, 1, 0, 0, 0, "R9 debug halt from exception");
        do_reset();
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_DBG,  0, 0, 0, S_H, 1, 0, 0, 0, "R9 debug halt from normal");
        do_reset();
        cyc(E_ACC|E_HDL, 0, 0, 0, S_H, 1, 0, 0, 0, "R11 double fault beats handler");
        do_reset();
        cyc(E_HDL,  0, 0, 0, S_N, 1, 0, 0, 0, "R2 handler issue");
        cyc(E_ADDR|E_IRQ, 7, 0, 0, S_E, 1, 1, 1, 1, "R11 fault with irq enters exception");
        cyc(0,      0, 0, 0, S_E, 1, 0, 0, 0, "R3 refill single cycle");
        @(negedge clk);
        set_ev(0, 0, 0, 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule